// File: doc/BRIEF.md
# Sync Word Detecting Deframer

This receive-side deframer watches a serial bit stream, one bit per cycle when `bit_valid_i` is high, and looks for a programmed sync word. Once the sync word is found, it gathers the raw payload that follows into bytes. It writes those bytes into an external FIFO and tells that FIFO to zero both of its pointers. When enabled, it then checks a 16-bit CRC. Finally it drops a trailer of configurable length and returns to searching.

The sync word, its length, the payload length, the CRC enable and the trailer length come in as static configuration inputs. They must stay stable while a packet is in progress. The block reports a pulse when sync is found, a pulse when the packet is complete, and an error flag that holds the CRC result.

Top module: `sync_deframer`

## Requirements
- R1: The width of the sync match is chosen by `sync_sel_i`: 0 selects 32 bits, 1 selects 48 bits, and 2 or 3 select 64 bits. The sync word sits in the low bits of `sync_word_i`, and the first bit received is compared with bit width-1. All selected bits must match exactly. A match also needs at least width valid bits received since the search began, and bits above the selected width are ignored.
- R2: `sync_found_o` and `fifo_ptr_clr_o` pulse high for one cycle, in the cycle after the edge that accepted the last sync bit. The clear pulse tells the FIFO to reset both its write pointer and its read pointer to 0.
- R3: The first payload byte after a sync is written at address 0, and each later byte goes to the next address up.
- R4: Payload bits are packed MSB first: the first bit received becomes bit 7 of the byte. `fifo_we_o` pulses for one cycle after the eighth bit of each byte.
- R5: Exactly `payload_len_i` bytes are written for each packet. Cycles in which `bit_valid_i` is low leave all state unchanged.
- R6: No sync search runs while a packet is in progress, so a sync pattern inside the payload does not produce a second `sync_found_o`.
- R7: When `crc_en_i` is 1, the 16 bits after the payload, taken MSB first, are compared with a CRC-16 computed over the payload bits in arrival order. The CRC uses polynomial 0x1021, initial value 0xFFFF, no reflection and no final XOR. `crc_err_o` goes to 1 on a mismatch and stays 0 on a match. It holds its value until the next sync detection clears it.
- R8: When `crc_en_i` is 0, no CRC field is expected, the trailer follows the payload directly, and `crc_err_o` stays 0.
- R9: After the CRC field, or after the payload when the CRC is disabled, `trailer_len_i` bits are discarded. The value is clamped to the range 4 to 16. `pkt_done_o` pulses for one cycle after the last trailer bit, and the search then starts again.
- R10: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_i | input | 1 | Serial receive bit |
| bit_valid_i | input | 1 | Qualifies bit_i |
| sync_word_i | input | 64 | Sync word, right aligned |
| sync_sel_i | input | 2 | Sync width select |
| payload_len_i | input | 8 | Payload length in bytes |
| crc_en_i | input | 1 | Enables the CRC field and its check |
| trailer_len_i | input | 5 | Trailer length in bits |
| fifo_we_o | output | 1 | FIFO write strobe |
| fifo_waddr_o | output | 8 | FIFO write address |
| fifo_wdata_o | output | 8 | FIFO write byte |
| fifo_ptr_clr_o | output | 1 | Clears the FIFO read and write pointers |
| sync_found_o | output | 1 | Sync detected pulse |
| pkt_done_o | output | 1 | Packet complete pulse |
| crc_err_o | output | 1 | CRC mismatch flag |

## Verification
The bench sends near-miss sync words that differ from the programmed word in one bit. A correlator that compares too few bits, or the wrong end of the word, would fire on them. It places the sync pattern inside a payload, which catches a design that keeps searching during a packet. It also starts a second packet, so an address counter that is not rewound shows up as writes that do not begin at 0. Further tests insert gaps in the valid strobe, flip one CRC bit to check that the error flag rises and then clears, and stop the trailer one bit short, so that a wrong trailer count or a missing clamp ends the packet at the wrong time.

// File: rtl/dfr_pkg.sv
package dfr_pkg;
  typedef enum logic [1:0] {
    ST_SRCH = 2'd0,
    ST_PAY  = 2'd1,
    ST_CRC  = 2'd2,
    ST_TRL  = 2'd3
  } dfr_state_t;

  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;
  localparam int TRL_MIN = 4;
  localparam int TRL_MAX = 16;
endpackage

// File: rtl/sync_corr.sv
module sync_corr #(
  parameter int SYNC_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              valid_i,
  input  logic              en_i,
  input  logic [SYNC_W-1:0] word_i,
  input  logic [1:0]        sel_i,
  output logic              hit_o
);
  localparam int FILL_W = $clog2(SYNC_W + 1);

  logic [SYNC_W-1:0] sh_q, sh_nxt, mask;
  logic [FILL_W-1:0] fill_q, fill_inc, need;

  always_comb begin
    case (sel_i)
      2'd0:    need = FILL_W'(SYNC_W / 2);
      2'd1:    need = FILL_W'((SYNC_W * 3) / 4);
      default: need = FILL_W'(SYNC_W);
    endcase
  end

  assign mask     = ~({SYNC_W{1'b1}} << need);
  assign sh_nxt   = {sh_q[SYNC_W-2:0], bit_i};
  assign fill_inc = (fill_q == FILL_W'(SYNC_W)) ? fill_q : fill_q + FILL_W'(1);
  assign hit_o    = en_i && valid_i && (fill_inc >= need) &&
                    (((sh_nxt ^ word_i) & mask) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      fill_q <= '0;
    end else if (!en_i) begin
      fill_q <= '0;
    end else if (valid_i) begin
      sh_q   <= sh_nxt;
      fill_q <= fill_inc;
    end
  end

  // R1: a hit needs enough history since the search began
  p_fill_before_hit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (fill_q >= need - FILL_W'(1)));
endmodule

// File: rtl/crc16_ser.sv
module crc16_ser import dfr_pkg::*; (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        step_i,
  input  logic        bit_i,
  output logic [15:0] crc_o
);
  logic fb;
  assign fb = crc_o[15] ^ bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_o <= CRC_INIT;
    else if (init_i) crc_o <= CRC_INIT;
    else if (step_i) crc_o <= {crc_o[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
  end
endmodule

// File: rtl/sync_deframer.sv
module sync_deframer import dfr_pkg::*; #(
  parameter int SYNC_W = 64,
  parameter int LEN_W  = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              bit_valid_i,
  input  logic [SYNC_W-1:0] sync_word_i,
  input  logic [1:0]        sync_sel_i,
  input  logic [LEN_W-1:0]  payload_len_i,
  input  logic              crc_en_i,
  input  logic [4:0]        trailer_len_i,
  output logic              fifo_we_o,
  output logic [ADDR_W-1:0] fifo_waddr_o,
  output logic [7:0]        fifo_wdata_o,
  output logic              fifo_ptr_clr_o,
  output logic              sync_found_o,
  output logic              pkt_done_o,
  output logic              crc_err_o
);
  dfr_state_t        state;
  logic              hit;
  logic [15:0]       crc_calc, crc_rx_nxt, crc_rx_q;
  logic [2:0]        bit_cnt;
  logic [7:0]        byte_sr, byte_nxt;
  logic [LEN_W-1:0]  byte_cnt;
  logic [ADDR_W-1:0] wptr;
  logic [4:0]        aux_cnt, trl_last;
  dfr_state_t        after_pay;

  sync_corr #(.SYNC_W(SYNC_W)) u_corr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bit_i   (bit_i),
    .valid_i (bit_valid_i),
    .en_i    (state == ST_SRCH),
    .word_i  (sync_word_i),
    .sel_i   (sync_sel_i),
    .hit_o   (hit)
  );

  crc16_ser u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (hit),
    .step_i (state == ST_PAY && bit_valid_i),
    .bit_i  (bit_i),
    .crc_o  (crc_calc)
  );

  always_comb begin
    if (trailer_len_i < 5'(TRL_MIN))      trl_last = 5'(TRL_MIN - 1);
    else if (trailer_len_i > 5'(TRL_MAX)) trl_last = 5'(TRL_MAX - 1);
    else                                  trl_last = trailer_len_i - 5'd1;
  end

  assign after_pay  = crc_en_i ? ST_CRC : ST_TRL;
  assign byte_nxt   = {byte_sr[6:0], bit_i};
  assign crc_rx_nxt = {crc_rx_q[14:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state          <= ST_SRCH;
      bit_cnt        <= '0;
      byte_sr        <= '0;
      byte_cnt       <= '0;
      wptr           <= '0;
      aux_cnt        <= '0;
      crc_rx_q       <= '0;
      fifo_we_o      <= 1'b0;
      fifo_waddr_o   <= '0;
      fifo_wdata_o   <= '0;
      fifo_ptr_clr_o <= 1'b0;
      sync_found_o   <= 1'b0;
      pkt_done_o     <= 1'b0;
      crc_err_o      <= 1'b0;
    end else begin
      fifo_we_o      <= 1'b0;
      fifo_ptr_clr_o <= 1'b0;
      sync_found_o   <= 1'b0;
      pkt_done_o     <= 1'b0;
      case (state)
        ST_SRCH: if (hit) begin
          state          <= (payload_len_i == '0) ? after_pay : ST_PAY;
          sync_found_o   <= 1'b1;
          fifo_ptr_clr_o <= 1'b1;
          wptr           <= '0;
          bit_cnt        <= '0;
          byte_cnt       <= '0;
          aux_cnt        <= '0;
          crc_err_o      <= 1'b0;
        end
        ST_PAY: if (bit_valid_i) begin
          byte_sr <= byte_nxt;
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            fifo_we_o    <= 1'b1;
            fifo_wdata_o <= byte_nxt;
            fifo_waddr_o <= wptr;
            wptr         <= wptr + ADDR_W'(1);
            byte_cnt     <= byte_cnt + LEN_W'(1);
            if (byte_cnt + LEN_W'(1) == payload_len_i) state <= after_pay;
          end
        end
        ST_CRC: if (bit_valid_i) begin
          crc_rx_q <= crc_rx_nxt;
          aux_cnt  <= aux_cnt + 5'd1;
          if (aux_cnt == 5'd15) begin
            crc_err_o <= (crc_rx_nxt != crc_calc);
            aux_cnt   <= '0;
            state     <= ST_TRL;
          end
        end
        ST_TRL: if (bit_valid_i) begin
          aux_cnt <= aux_cnt + 5'd1;
          if (aux_cnt == trl_last) begin
            pkt_done_o <= 1'b1;
            aux_cnt    <= '0;
            state      <= ST_SRCH;
          end
        end
        default: state <= ST_SRCH;
      endcase
    end
  end

  p_we_from_payload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_we_o |-> $past(state == ST_PAY));
  p_first_addr_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_PAY && byte_cnt == '0) |-> (wptr == '0));
  p_no_resync_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_found_o |=> !sync_found_o);
  p_err_from_crc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(crc_err_o) |-> $past(state == ST_CRC));
  p_done_from_trailer_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_done_o |-> ($past(state == ST_TRL) && state == ST_SRCH));
  p_clr_with_sync_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fifo_ptr_clr_o) |-> $past(state == ST_SRCH));
endmodule

// File: tb/sim_sync_deframer.sv
module sim_sync_deframer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_d = 1'b0, vld = 1'b0;
  logic [63:0] sword = '0;
  logic [1:0]  ssel = '0;
  logic [7:0]  plen = '0;
  logic        crcen = 1'b0;
  logic [4:0]  tlen = 5'd4;
  logic        we, clr, sf, done, cerr;
  logic [7:0]  waddr, wdata;

  int checks = 0, fails = 0;
  int wr_n = 0, sync_n = 0, done_n = 0, clr_n = 0;
  logic [7:0] cap_data [0:255];
  logic [7:0] cap_addr [0:255];

  always #2 clk = ~clk;

  sync_deframer u0 (
    .clk_i(clk), .rst_ni(rst_n), .bit_i(bit_d), .bit_valid_i(vld),
    .sync_word_i(sword), .sync_sel_i(ssel), .payload_len_i(plen),
    .crc_en_i(crcen), .trailer_len_i(tlen),
    .fifo_we_o(we), .fifo_waddr_o(waddr), .fifo_wdata_o(wdata),
    .fifo_ptr_clr_o(clr), .sync_found_o(sf), .pkt_done_o(done), .crc_err_o(cerr)
  );

  always @(negedge clk) begin
    if (we) begin
      cap_data[wr_n[7:0]] = wdata;
      cap_addr[wr_n[7:0]] = waddr;
      wr_n++;
    end
    if (sf) sync_n++;
    if (done) done_n++;
    if (clr) clr_n++;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_of(input logic [63:0] d, input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 8 * n - 1; i >= 0; i--) begin
      logic fb = c[15] ^ d[i];
      c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    return c;
  endfunction

  task automatic send_bits(input logic [63:0] v, input int n, input bit gap);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); bit_d = v[i]; vld = 1'b1;
      if (gap) begin @(negedge clk); vld = 1'b0; bit_d = ~bit_d; end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); vld = 1'b0; end
  endtask

  // sends one packet and checks bytes, addresses, pulses and the CRC flag
  task automatic pkt(input string req, input logic [63:0] sw, input logic [1:0] sel,
                     input int slen, input logic [63:0] pay, input int n,
                     input bit ce, input bit corrupt, input bit gap);
    int w0 = wr_n, s0 = sync_n, d0 = done_n;
    logic [15:0] c;
    sword = sw; ssel = sel; plen = 8'(n); crcen = ce; tlen = 5'd6;
    send_bits(sw, slen, gap);
    for (int b = 0; b < n; b++) send_bits({56'd0, pay[8*(n-1-b) +: 8]}, 8, gap);
    c = crc_of(pay, n) ^ (corrupt ? 16'h0008 : 16'h0000);
    if (ce) send_bits({48'd0, c}, 16, gap);
    send_bits(64'h2D, 6, gap);
    idle(3);
    chk(sync_n - s0 == 1, {req, " R1 sync count"}, sync_n - s0, 1);
    chk(wr_n - w0 == n, {req, " R5 byte count"}, wr_n - w0, n);
    for (int b = 0; b < n && b < wr_n - w0; b++) begin
      chk(cap_data[8'(w0 + b)] == pay[8*(n-1-b) +: 8], {req, " R4 byte"},
          cap_data[8'(w0 + b)], pay[8*(n-1-b) +: 8]);
      chk(cap_addr[8'(w0 + b)] == 8'(b), {req, " R3 addr"}, cap_addr[8'(w0 + b)], b);
    end
    chk(done_n - d0 == 1, {req, " R9 done"}, done_n - d0, 1);
    chk(cerr == (ce && corrupt), {req, " R7 crc flag"}, cerr, ce && corrupt);
  endtask

  task automatic t_reset;
    chk(!we && !clr && !sf && !done && !cerr && waddr == 0 && wdata == 0,
        "R10 reset outputs", {we, clr, sf, done, cerr}, 0);
  endtask

  task automatic t_pulse;
    int s0 = sync_n;
    sword = 64'hC0FF_EE12; ssel = 2'd0; plen = 8'd1; crcen = 1'b0; tlen = 5'd4;
    send_bits(sword, 32, 1'b0);
    idle(1);
    chk(sf && clr, "R2 pulses after last sync bit", {sf, clr}, 2'b11);
    idle(1);
    chk(!sf && !clr, "R2 pulses last one cycle", {sf, clr}, 0);
    chk(sync_n - s0 == 1, "R2 single sync pulse", sync_n - s0, 1);
    send_bits(64'h5A, 8, 1'b0);
    send_bits(64'hF, 4, 1'b0);
    idle(3);
    chk(wr_n > 0 && cap_data[8'(wr_n - 1)] == 8'h5A, "R4 msb first", cap_data[8'(wr_n - 1)], 8'h5A);
    chk(cerr == 1'b0, "R8 no crc flag when disabled", cerr, 0);
  endtask

  task automatic t_near_miss;
    int s0 = sync_n;
    sword = 64'h0000_A5C3_0F96_7E21; ssel = 2'd1; plen = 8'd2; crcen = 1'b1;
    send_bits(sword ^ 64'h1, 48, 1'b0);
    idle(2);
    send_bits(sword ^ 64'h8000_0000_0000, 48, 1'b0);
    idle(2);
    chk(sync_n == s0, "R1 48-bit near miss rejected", sync_n - s0, 0);
    ssel = 2'd2; sword = 64'h9E37_79B9_7F4A_7C15;
    send_bits(sword ^ 64'h8000_0000_0000_0000, 64, 1'b0);
    idle(2);
    chk(sync_n == s0, "R1 64-bit top bit near miss rejected", sync_n - s0, 0);
  endtask

  task automatic t_trailer;
    int d0 = done_n;
    sword = 64'h1234_5678; ssel = 2'd0; plen = 8'd1; crcen = 1'b0; tlen = 5'd2;
    send_bits(sword, 32, 1'b0);
    send_bits(64'h3C, 8, 1'b0);
    send_bits(64'h5, 3, 1'b0);
    idle(3);
    chk(done_n == d0, "R9 clamped trailer not done early", done_n - d0, 0);
    send_bits(64'h1, 1, 1'b0);
    idle(1);
    chk(done, "R9 done after fourth trailer bit", done, 1);
    idle(2);
    chk(done_n - d0 == 1, "R9 single done pulse", done_n - d0, 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_pulse();
        pkt("p32crc", 64'hD391_D391, 2'd0, 32, 64'h11_22_33, 3, 1'b1, 1'b0, 1'b0);
        pkt("p32bad", 64'hD391_D391, 2'd0, 32, 64'h11_22_33, 3, 1'b1, 1'b1, 1'b0);
        t_near_miss();
        pkt("p48upper", 64'hFFFF_A5C3_0F96_7E21, 2'd1, 64, 64'hA0_B1, 2, 1'b1, 1'b0, 1'b0);
        chk(cerr == 1'b0, "R7 flag cleared by new sync", cerr, 0);
        pkt("p64gap", 64'h9E37_79B9_7F4A_7C15, 2'd2, 64, 64'h01_80_FE_7F, 4, 1'b0, 1'b0, 1'b1);
        // R6: sync pattern inside payload is not searched
        pkt("r6_embed", 64'hCAFE_F00D, 2'd0, 32, 64'hCAFE_F00D_CAFE_F00D, 8, 1'b1, 1'b0, 1'b0);
        t_trailer();
        chk(clr_n == sync_n, "R2 clear pulses match sync pulses", clr_n, sync_n);
      end
      begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule